// File: doc/BRIEF.md
# Manual Serial Line Sequencer

This block lets software drive a serial slave interface one line-level step at a time. Each accepted command word holds a write flag, a 4-bit operation code and an 8-bit operand. A step can drive chip select high, drive it low, give one clock pulse, or shift the operand out most significant bit first on one, two or four data lanes. Software builds whole frames from these steps. A typical use is to put a serial slave back into a known state before the automatic transfer channel is switched on.

The sequencer accepts commands only while both the manual enable and the path-select input are high. While that pair is high it also forces the automatic channel enable and the dual-lane enable to zero. A busy flag covers each step. A separate idle indication reports when no step is running and the lines are in their rest state, which is chip select high and clock low.

Top module: `man_spi_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, sdo is 0, busy is 0, sync_idle is 1, and auto_en and dio_en are 0.
- R2: A command is accepted only on a cycle where cmd_wr, man_en, mux_sel and cmd_data[13] (write flag) are all 1. The operation code is cmd_data[11:8] and the operand is cmd_data[7:0]. Any other command has no effect on the lines or on busy.
- R3: Opcode 0 sets cs_n to 1 and opcode 1 sets cs_n to 0, at the accepting edge. Each holds busy for exactly one cycle.
- R4: Opcode 2 gives one sck pulse: SCK_HALF cycles low, then SCK_HALF cycles high. busy lasts 2*SCK_HALF cycles and sdo does not change.
- R5: Opcode 8 shifts the operand MSB first on sdo[0] over 8 sck pulses, with sdo[3:1] at 0. Each bit is valid on the rising sck edge.
- R6: Opcode 9 shifts the operand over 4 pulses, two bits per pulse, on sdo[1:0]. The higher-order bit is on sdo[1] and sdo[3:2] is 0.
- R7: Opcode 10 shifts the operand over 2 pulses, four bits per pulse, on sdo[3:0]. The higher nibble goes first.
- R8: busy rises at the accepting edge and falls at the final falling sck edge of the step, so a step with N pulses is busy for 2*SCK_HALF*N cycles. Commands that arrive while busy is high are dropped.
- R9: Opcodes other than 0, 1, 2, 8, 9 and 10 hold busy for one cycle and leave cs_n, sck and sdo unchanged.
- R10: auto_en and dio_en follow auto_en_req and dio_en_req with one cycle of delay. They are forced to 0 in the cycle after man_en and mux_sel are both 1.
- R11: sync_idle is 1 exactly when no step is running, cs_n is 1 and sck is 0.
- R12: The slave-recovery sequence runs fully and ends with the lines at rest: chip select low, one single-lane output, chip select high, then four more single-lane outputs, 40 pulses in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_en | input | 1 | Manual mode enable |
| mux_sel | input | 1 | Routes the serial lines to the manual engine |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | CMD_W | Command word: write flag, opcode, operand |
| auto_en_req | input | 1 | Requested automatic channel enable |
| dio_en_req | input | 1 | Requested dual-lane enable |
| busy | output | 1 | A step is in progress |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| sdo | output | 4 | Serial data out lanes |
| sync_idle | output | 1 | No step running and lines at rest |
| auto_en | output | 1 | Gated automatic channel enable |
| dio_en | output | 1 | Gated dual-lane enable |

## Verification
The bench builds the block with SCK_HALF set to 2 and the 8-bit operand width. With that setting every clock phase lasts two cycles, so a phase counter that never reaches zero or stops one count early changes the measured busy windows (8, 16 and 32 cycles for the shift modes). The short half period also keeps the 40-pulse recovery sequence quick enough to run alongside lane-ordering checks in all three widths, a command dropped during a shift, and the enable gating.

// File: rtl/man_seq_pkg.sv
package man_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIN,
        ST_LOW,
        ST_HIGH
    } seq_st_e;

    typedef enum logic [1:0] {
        LN_ONE,
        LN_TWO,
        LN_FOUR
    } lane_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_CS_HI,
        K_CS_LO,
        K_PULSE,
        K_SHIFT
    } kind_e;

    localparam logic [3:0] OPC_CS_HI  = 4'd0;
    localparam logic [3:0] OPC_CS_LO  = 4'd1;
    localparam logic [3:0] OPC_PULSE  = 4'd2;
    localparam logic [3:0] OPC_OUT_1  = 4'd8;
    localparam logic [3:0] OPC_OUT_2  = 4'd9;
    localparam logic [3:0] OPC_OUT_4  = 4'd10;

endpackage

// File: rtl/man_seq_decode.sv
module man_seq_decode
    import man_seq_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int OPND_W = 8,
    parameter int WR_BIT = 13,
    parameter int OP_LSB = 8,
    parameter int OP_W   = 4,
    localparam int BEAT_W = $clog2(OPND_W)
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic              strobe,
    input  logic              active,
    output logic              req,
    output kind_e             kind,
    output lane_e             lane,
    output logic [BEAT_W-1:0] beats_m1,
    output logic [OPND_W-1:0] operand
);

    logic [OP_W-1:0] opc;
    logic            unused_bits;

    assign opc         = cmd[OP_LSB +: OP_W];
    assign operand     = cmd[OPND_W-1:0];
    assign req         = strobe & active & cmd[WR_BIT];
    assign unused_bits = ^{cmd[CMD_W-1:WR_BIT+1], cmd[WR_BIT-1:OP_LSB+OP_W]};

    always_comb begin
        kind     = K_NONE;
        lane     = LN_ONE;
        beats_m1 = '0;
        case (opc)
            OPC_CS_HI: kind = K_CS_HI;
            OPC_CS_LO: kind = K_CS_LO;
            OPC_PULSE: kind = K_PULSE;
            OPC_OUT_1: begin
                kind     = K_SHIFT;
                lane     = LN_ONE;
                beats_m1 = BEAT_W'(OPND_W - 1);
            end
            OPC_OUT_2: begin
                kind     = K_SHIFT;
                lane     = LN_TWO;
                beats_m1 = BEAT_W'(OPND_W / 2 - 1);
            end
            OPC_OUT_4: begin
                kind     = K_SHIFT;
                lane     = LN_FOUR;
                beats_m1 = BEAT_W'(OPND_W / 4 - 1);
            end
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/man_seq_lanes.sv
module man_seq_lanes
    import man_seq_pkg::*;
#(
    parameter int OPND_W = 8
) (
    input  logic [OPND_W-1:0] data,
    input  lane_e             lane,
    output logic [3:0]        lanes
);

    always_comb begin
        case (lane)
            LN_ONE:  lanes = {3'b000, data[OPND_W-1]};
            LN_TWO:  lanes = {2'b00, data[OPND_W-1 -: 2]};
            LN_FOUR: lanes = data[OPND_W-1 -: 4];
            default: lanes = 4'b0000;
        endcase
    end

endmodule

// File: rtl/man_spi_seq.sv
module man_spi_seq
    import man_seq_pkg::*;
#(
    parameter int CMD_W    = 16,
    parameter int OPND_W   = 8,
    parameter int SCK_HALF = 4,
    localparam int BEAT_W  = $clog2(OPND_W),
    localparam int PH_W    = $clog2(SCK_HALF) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_en,
    input  logic             mux_sel,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             auto_en_req,
    input  logic             dio_en_req,
    output logic             busy,
    output logic             cs_n,
    output logic             sck,
    output logic [3:0]       sdo,
    output logic             sync_idle,
    output logic             auto_en,
    output logic             dio_en
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCK_HALF - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [PH_W-1:0]   ph;
        logic [BEAT_W-1:0] beats;
        logic [OPND_W-1:0] shreg;
        lane_e             lane;
        logic              shift;
        logic              cs_n;
        logic              sck;
        logic [3:0]        sdo;
        logic              auto_en;
        logic              dio_en;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st:      ST_IDLE,
        ph:      '0,
        beats:   '0,
        shreg:   '0,
        lane:    LN_ONE,
        shift:   1'b0,
        cs_n:    1'b1,
        sck:     1'b0,
        sdo:     4'b0000,
        auto_en: 1'b0,
        dio_en:  1'b0
    };

    regs_t s_q, s_d;

    logic              active;
    logic              dec_req;
    kind_e             dec_kind;
    lane_e             dec_lane;
    logic [BEAT_W-1:0] dec_beats;
    logic [OPND_W-1:0] dec_operand;
    logic [OPND_W-1:0] shifted;
    logic [OPND_W-1:0] lane_src;
    lane_e             lane_sel;
    logic [3:0]        lane_out;

    assign active = man_en & mux_sel;

    man_seq_decode #(
        .CMD_W  (CMD_W),
        .OPND_W (OPND_W)
    ) u_decode (
        .cmd      (cmd_data),
        .strobe   (cmd_wr),
        .active   (active),
        .req      (dec_req),
        .kind     (dec_kind),
        .lane     (dec_lane),
        .beats_m1 (dec_beats),
        .operand  (dec_operand)
    );

    always_comb begin
        case (s_q.lane)
            LN_FOUR: shifted = s_q.shreg << 4;
            LN_TWO:  shifted = s_q.shreg << 2;
            default: shifted = s_q.shreg << 1;
        endcase
    end

    assign lane_src = (s_q.st == ST_IDLE) ? dec_operand : shifted;
    assign lane_sel = (s_q.st == ST_IDLE) ? dec_lane : s_q.lane;

    man_seq_lanes #(
        .OPND_W (OPND_W)
    ) u_lanes (
        .data  (lane_src),
        .lane  (lane_sel),
        .lanes (lane_out)
    );

    always_comb begin
        s_d         = s_q;
        s_d.auto_en = auto_en_req & ~active;
        s_d.dio_en  = dio_en_req & ~active;

        case (s_q.st)
            ST_IDLE: begin
                if (dec_req) begin
                    case (dec_kind)
                        K_CS_HI: begin
                            s_d.cs_n = 1'b1;
                            s_d.st   = ST_FIN;
                        end
                        K_CS_LO: begin
                            s_d.cs_n = 1'b0;
                            s_d.st   = ST_FIN;
                        end
                        K_PULSE: begin
                            s_d.st    = ST_LOW;
                            s_d.ph    = PH_LAST;
                            s_d.beats = '0;
                            s_d.shift = 1'b0;
                        end
                        K_SHIFT: begin
                            s_d.st    = ST_LOW;
                            s_d.ph    = PH_LAST;
                            s_d.beats = dec_beats;
                            s_d.lane  = dec_lane;
                            s_d.shreg = dec_operand;
                            s_d.sdo   = lane_out;
                            s_d.shift = 1'b1;
                        end
                        default: s_d.st = ST_FIN;
                    endcase
                end
            end
            ST_FIN: begin
                s_d.st = ST_IDLE;
            end
            ST_LOW: begin
                if (s_q.ph == '0) begin
                    s_d.st  = ST_HIGH;
                    s_d.ph  = PH_LAST;
                    s_d.sck = 1'b1;
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
            ST_HIGH: begin
                if (s_q.ph == '0) begin
                    s_d.sck = 1'b0;
                    if (s_q.beats == '0) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.beats = s_q.beats - 1'b1;
                        s_d.st    = ST_LOW;
                        s_d.ph    = PH_LAST;
                        if (s_q.shift) begin
                            s_d.shreg = shifted;
                            s_d.sdo   = lane_out;
                        end
                    end
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RESET_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign cs_n      = s_q.cs_n;
    assign sck       = s_q.sck;
    assign sdo       = s_q.sdo;
    assign sync_idle = (s_q.st == ST_IDLE) & s_q.cs_n & ~s_q.sck;
    assign auto_en   = s_q.auto_en;
    assign dio_en    = s_q.dio_en;

endmodule

// File: rtl/man_seq_chk.sv
module man_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       man_en,
    input logic       mux_sel,
    input logic       busy,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] sdo,
    input logic       auto_en,
    input logic       dio_en
);

    p_no_idle_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    p_rise_in_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> busy);

    p_cs_hold_in_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));

    p_data_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo));

    p_inactive_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(man_en && mux_sel) && !busy) |=> !busy);

    p_enables_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && mux_sel) |=> (!auto_en && !dio_en));

endmodule

bind man_spi_seq man_seq_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .man_en  (man_en),
    .mux_sel (mux_sel),
    .busy    (busy),
    .cs_n    (cs_n),
    .sck     (sck),
    .sdo     (sdo),
    .auto_en (auto_en),
    .dio_en  (dio_en)
);

// File: tb/man_spi_seq_tb_top.sv
module man_spi_seq_tb_top;

    localparam int HALF = 2;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        man_en = 1'b0;
    logic        mux_sel = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        auto_en_req = 1'b0;
    logic        dio_en_req = 1'b0;
    logic        busy, cs_n, sck, sync_idle, auto_en, dio_en;
    logic [3:0]  sdo;

    int   n_chk = 0;
    int   n_fail = 0;
    int   pulses = 0;
    logic prev_sck = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    man_spi_seq #(
        .CMD_W    (16),
        .OPND_W   (8),
        .SCK_HALF (HALF)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .man_en      (man_en),
        .mux_sel     (mux_sel),
        .cmd_wr      (cmd_wr),
        .cmd_data    (cmd_data),
        .auto_en_req (auto_en_req),
        .dio_en_req  (dio_en_req),
        .busy        (busy),
        .cs_n        (cs_n),
        .sck         (sck),
        .sdo         (sdo),
        .sync_idle   (sync_idle),
        .auto_en     (auto_en),
        .dio_en      (dio_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare lanes at each rising sck
    always @(negedge clk) begin
        if (rst_n && sck && !prev_sck) begin
            pulses++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.val >= 0) chk(sdo == e.val[3:0], e.tag, int'(sdo), e.val);
            end
        end
        prev_sck = sck;
    end

    task automatic push_groups(input int width, input logic [7:0] d, input string tag);
        for (int i = 0; i < 8 / width; i++) begin
            exp_t e;
            logic [7:0] s;
            s = d << (i * width);
            case (width)
                1:       e.val = {28'd0, 3'b000, s[7]};
                2:       e.val = {28'd0, 2'b00, s[7:6]};
                default: e.val = {28'd0, s[7:4]};
            endcase
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic step(input bit wr, input logic [3:0] op, input logic [7:0] d,
                        input int exp_busy, input string tag);
        int n;
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_data = {2'b00, wr, 1'b0, op, d};
        @(negedge clk);
        cmd_wr = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_busy, tag, n, exp_busy);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] sdo_keep;
        int p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(sdo == 4'h0, "R1 sdo", sdo, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(sync_idle == 1'b1, "R1 sync_idle", sync_idle, 1);
        chk(auto_en == 1'b0 && dio_en == 1'b0, "R1 enables", {auto_en, dio_en}, 0);

        // R10 gating of enables
        auto_en_req = 1'b1;
        dio_en_req  = 1'b1;
        repeat (2) @(negedge clk);
        chk(auto_en && dio_en, "R10 follow req", {auto_en, dio_en}, 3);
        man_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(auto_en && dio_en, "R10 man_en alone", {auto_en, dio_en}, 3);
        mux_sel = 1'b1;
        repeat (2) @(negedge clk);
        chk(!auto_en && !dio_en, "R10 forced low", {auto_en, dio_en}, 0);

        // R2 command without write flag is ignored
        step(1'b0, 4'd1, 8'h00, 0, "R2 no write flag busy");
        chk(cs_n == 1'b1, "R2 no write flag cs_n", cs_n, 1);
        // R2 command while inactive is ignored
        man_en = 1'b0;
        step(1'b1, 4'd1, 8'h00, 0, "R2 inactive busy");
        chk(cs_n == 1'b1, "R2 inactive cs_n", cs_n, 1);
        man_en = 1'b1;

        // R3 chip select low
        step(1'b1, 4'd1, 8'h00, 1, "R3 cs low busy");
        chk(cs_n == 1'b0, "R3 cs low", cs_n, 0);
        chk(sync_idle == 1'b0, "R11 not idle with cs low", sync_idle, 0);

        // R5 / R6 / R7 shift modes
        push_groups(1, 8'hA5, "R5 single lane");
        step(1'b1, 4'd8, 8'hA5, 2 * HALF * 8, "R5 single busy");
        push_groups(2, 8'h3C, "R6 dual lane");
        step(1'b1, 4'd9, 8'h3C, 2 * HALF * 4, "R6 dual busy");
        push_groups(4, 8'h96, "R7 quad lane");
        step(1'b1, 4'd10, 8'h96, 2 * HALF * 2, "R7 quad busy");

        // R4 clock pulse
        sdo_keep = sdo;
        begin
            exp_t e;
            e.val = -1;
            e.tag = "R4";
            exp_q.push_back(e);
        end
        p0 = pulses;
        step(1'b1, 4'd2, 8'hFF, 2 * HALF, "R4 pulse busy");
        chk(pulses - p0 == 1, "R4 pulse count", pulses - p0, 1);
        chk(sdo == sdo_keep, "R4 sdo unchanged", sdo, sdo_keep);

        // R9 unused opcode
        sdo_keep = sdo;
        step(1'b1, 4'd5, 8'h77, 1, "R9 unused busy");
        chk(cs_n == 1'b0 && sdo == sdo_keep, "R9 lines unchanged", {cs_n, sdo}, {1'b0, sdo_keep});

        // R8 command dropped while busy
        push_groups(1, 8'hC3, "R8 shift under drop");
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_data = {2'b00, 1'b1, 1'b0, 4'd8, 8'hC3};
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (3) @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_data = {2'b00, 1'b1, 1'b0, 4'd0, 8'h00};
        @(negedge clk);
        cmd_wr = 1'b0;
        while (busy) @(negedge clk);
        chk(cs_n == 1'b0, "R8 dropped cs high", cs_n, 0);

        // R3 chip select high, R11 idle
        step(1'b1, 4'd0, 8'h00, 1, "R3 cs high busy");
        chk(cs_n == 1'b1, "R3 cs high", cs_n, 1);
        chk(sync_idle == 1'b1, "R11 idle at rest", sync_idle, 1);

        // R12 slave recovery sequence
        p0 = pulses;
        step(1'b1, 4'd1, 8'h00, 1, "R12 cs low");
        push_groups(1, 8'h00, "R12 out");
        step(1'b1, 4'd8, 8'h00, 2 * HALF * 8, "R12 out busy");
        step(1'b1, 4'd0, 8'h00, 1, "R12 cs high");
        for (int k = 0; k < 4; k++) begin
            push_groups(1, 8'h00, "R12 trailing out");
            step(1'b1, 4'd8, 8'h00, 2 * HALF * 8, "R12 trailing busy");
        end
        chk(pulses - p0 == 40, "R12 pulse total", pulses - p0, 40);
        chk(cs_n == 1'b1 && sync_idle == 1'b1, "R12 rest state", {cs_n, sync_idle}, 3);

        // R10 release after manual mode
        man_en  = 1'b0;
        mux_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk(auto_en && dio_en, "R10 released", {auto_en, dio_en}, 3);

        chk(exp_q.size() == 0, "R5 pending lane items", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule